// File: doc/BRIEF.md
# Three-Wire Serial Register Interface

This block is the slave side of a three-wire serial link. A host uses it to reach a bank of clock registers and a 31-byte scratch RAM. The host raises a chip enable, toggles a serial clock and moves bits on one shared data line. The block turns this traffic into single-cycle read and write strobes. Each strobe carries an address and a space select, and the register file and the RAM sit outside the block. During reads the block drives the data line. It has its own output-enable signal for the pad.

Every transaction opens with an 8-bit command word. The word is shifted in least significant bit first. Its fields are: bit 0 gives the direction (0 = write, 1 = read), bits 5..1 give the address, bit 6 selects the space (0 = clock registers, 1 = RAM), and bit 7 enables writes (1 = allowed). One data byte follows the command, or a burst of data bytes. Data bytes also travel least significant bit first.

All port signals are synchronous to the system clock `clk`. Serial clock edges are detected by comparing `sclk` with its value one system clock earlier.

Top module: `tw_serial_slave`

## Requirements
- R1: While `ce` is low, the block is idle and `sdio_oe` is 0 one system clock after `ce` falls. Dropping `ce` in the middle of a transaction ends it, and the next transaction decodes a fresh command.
- R2: `sdio_i` is sampled on each rising `sclk` edge while `ce` is high. The first eight bits form the command, taken least significant bit first. Data bytes are also taken least significant bit first.
- R3: When command bit 7 is 0, no `wr_stb` is issued for that transaction, so the target byte keeps its value. A read is still served.
- R4: Command bit 6 drives `reg_space`: 0 selects the clock registers and 1 selects the RAM.
- R5: Command bits 5..1 give `reg_addr`. Command bit 0 selects a write when 0 and a read when 1.
- R6: In single-byte mode, exactly one data byte is transferred. Extra write bytes are ignored. After a single read byte, the next falling `sclk` edge releases the data line.
- R7: An address field of 31 (all ones) selects burst mode. The burst starts at address 0 and steps by one after each byte, for at most 31 bytes (addresses 0..30). A 32nd byte has no effect.
- R8: For a read, each output bit is placed on `sdio_o` after a falling `sclk` edge, least significant bit first. `sdio_oe` is 1 only while read data is being presented, and is never 1 during a write transaction.
- R9: A data byte is committed only after its 8th bit. A partial byte cut off by `ce` going low is discarded.
- R10: `wr_stb` and `rd_stb` are single-cycle pulses. `wr_data`, `reg_addr` and `reg_space` are valid while `wr_stb` is high. `rd_data` is sampled in the cycle `rd_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable; high for the whole transaction |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Data bit driven during reads |
| sdio_oe | output | 1 | Pad output enable for the data line |
| reg_space | output | 1 | 0 = clock registers, 1 = RAM |
| reg_addr | output | AW | Register or RAM address |
| wr_stb | output | 1 | Write strobe, one cycle |
| wr_data | output | DW | Write data |
| rd_stb | output | 1 | Read request, one cycle |
| rd_data | input | DW | Read data returned by the addressed storage |

## Verification
The hardest case to reach is the edge of a burst. The address must stop at 30, and a 32nd byte must neither wrap to address 0 nor be written. The burst read must refetch a new byte in the short window between the last bit of one byte and the first falling edge of the next. The bench drives a 32-byte burst write, then a full 31-byte burst read, and then reads address 0 on its own. Other stimuli cut `ce` partway through a data byte and partway through a read, so that partial-byte discard and line release are observed at the ports.

// File: rtl/tw_serial_slave.sv
module tw_serial_slave #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int BURST_LEN = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          sclk,
  input  logic          sdio_i,
  output logic          sdio_o,
  output logic          sdio_oe,
  output logic          reg_space,
  output logic [AW-1:0] reg_addr,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          rd_stb,
  input  logic [DW-1:0] rd_data
);
  localparam int BW = $clog2(DW);
  localparam logic [AW-1:0] LAST_ADDR = AW'(BURST_LEN - 1);

  typedef enum logic [1:0] {S_CMD, S_WR, S_RD, S_END} st_t;

  st_t           st;
  logic          sclk_q, burst, wen, fin, step;
  logic [BW-1:0] bcnt, obit;
  logic [DW-2:0] sh;
  logic [DW-1:0] ob;

  wire          rise      = ce & sclk & ~sclk_q;
  wire          fall      = ce & ~sclk & sclk_q;
  wire [DW-1:0] byte_in   = {sdio_i, sh};
  wire          byte_done = rise && (bcnt == BW'(DW - 1));
  wire          at_end    = (reg_addr == LAST_ADDR);
  wire          all_ones  = &byte_in[AW:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; sclk_q <= 1'b0; burst <= 1'b0; wen <= 1'b0; fin <= 1'b0;
      step <= 1'b0; bcnt <= '0; obit <= '0; sh <= '0; ob <= '0;
      sdio_o <= 1'b0; sdio_oe <= 1'b0; reg_space <= 1'b0; reg_addr <= '0;
      wr_stb <= 1'b0; wr_data <= '0; rd_stb <= 1'b0;
    end else begin
      sclk_q <= sclk;
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      step   <= 1'b0;
      if (rd_stb) ob <= rd_data;
      if (!ce) begin
        st <= S_CMD; bcnt <= '0; obit <= '0; sdio_oe <= 1'b0; fin <= 1'b0;
      end else begin
        if (rise) begin
          sh   <= byte_in[DW-1:1];
          bcnt <= bcnt + 1'b1;
        end
        if (step) reg_addr <= reg_addr + 1'b1;
        case (st)
          S_CMD: if (byte_done) begin
            wen       <= byte_in[DW-1];
            reg_space <= byte_in[DW-2];
            burst     <= all_ones;
            reg_addr  <= all_ones ? '0 : byte_in[AW:1];
            obit      <= '0;
            if (byte_in[0]) begin
              st     <= S_RD;
              rd_stb <= 1'b1;
            end else begin
              st <= S_WR;
            end
          end
          S_WR: if (byte_done) begin
            wr_stb  <= wen;
            wr_data <= byte_in;
            if (burst && !at_end) step <= 1'b1;
            else st <= S_END;
          end
          S_RD: if (fall) begin
            if (fin) begin
              sdio_oe <= 1'b0;
              st      <= S_END;
            end else begin
              sdio_oe <= 1'b1;
              sdio_o  <= ob[obit];
              obit    <= obit + 1'b1;
              if (obit == BW'(DW - 1)) begin
                if (burst && !at_end) begin
                  reg_addr <= reg_addr + 1'b1;
                  rd_stb   <= 1'b1;
                end else begin
                  fin <= 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_serial_slave_chk.sv
module tw_serial_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ce,
  input logic sdio_oe,
  input logic wr_stb,
  input logic rd_stb
);
  assert_oe_off_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !sdio_oe);
  assert_write_needs_ce_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(ce));
  assert_wr_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_rd_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);
  assert_no_write_while_driving_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !wr_stb);
endmodule

bind tw_serial_slave tw_serial_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .sdio_oe(sdio_oe),
  .wr_stb(wr_stb), .rd_stb(rd_stb)
);

// File: tb/tb_tw_serial_slave.sv
module tb_tw_serial_slave;
  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, reg_space, wr_stb, rd_stb;
  logic [4:0] reg_addr;
  logic [7:0] wr_data, rd_data;

  logic [7:0] sto_clk [32];
  logic [7:0] sto_ram [32];
  logic [7:0] exp_clk [32];
  logic [7:0] exp_ram [32];

  int nchk = 0, nfail = 0;
  bit writing = 1'b0, ce_q = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  tw_serial_slave dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .reg_space(reg_space), .reg_addr(reg_addr),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data)
  );

  assign rd_data = reg_space ? sto_ram[reg_addr] : sto_clk[reg_addr];

  always @(posedge clk)
    if (wr_stb) begin
      if (reg_space) sto_ram[reg_addr] <= wr_data;
      else sto_clk[reg_addr] <= wr_data;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!ce && !ce_q) chk(!sdio_oe, "R1 line released while idle", sdio_oe, 0);
      if (writing) chk(!sdio_oe, "R8 line released during write", sdio_oe, 0);
    end
    ce_q = ce;
  end

  function automatic logic [7:0] mk_cmd(bit we, bit ram, logic [4:0] a, bit rd);
    return {we, ram, a, rd};
  endfunction

  task automatic bit_cycle(input bit b);
    @(negedge clk); sclk = 1'b0; sdio_i = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bit_cycle(b[i]);
  endtask

  task automatic recv_byte(output logic [7:0] b, input string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk = 1'b0;
      repeat (4) @(negedge clk);
      chk(sdio_oe, req, sdio_oe, 1);
      b[i] = sdio_o;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic start_tx(input bit wr);
    @(negedge clk); ce = 1'b1; writing = wr;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_tx();
    @(negedge clk); sclk = 1'b0;
    repeat (2) @(negedge clk);
    ce = 1'b0; writing = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr1(input bit we, input bit ram, input logic [4:0] a, input logic [7:0] d);
    start_tx(1);
    send_byte(mk_cmd(we, ram, a, 0));
    send_byte(d);
    end_tx();
    if (we) begin
      if (ram) exp_ram[a] = d; else exp_clk[a] = d;
    end
  endtask

  task automatic rd1(input bit ram, input logic [4:0] a, input string req);
    logic [7:0] v, e;
    start_tx(0);
    send_byte(mk_cmd(1, ram, a, 1));
    recv_byte(v, req);
    e = ram ? exp_ram[a] : exp_clk[a];
    chk(v == e, req, v, e);
    @(negedge clk); sclk = 1'b0;
    repeat (4) @(negedge clk);
    chk(!sdio_oe, "R6 line released after single read byte", sdio_oe, 0);
    end_tx();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      sto_clk[i] = 8'h00; sto_ram[i] = 8'h00; exp_clk[i] = 8'h00; exp_ram[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    chk(!sdio_oe && !wr_stb && !rd_stb, "R1 reset state", {sdio_oe, wr_stb, rd_stb}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R4 R5: single write to RAM, LSB first
    wr1(1, 1, 5'd5, 8'hA5);
    rd1(1, 5'd5, "R2 R5 RAM single read");
    rd1(0, 5'd5, "R4 clock space untouched by RAM write");
    wr1(1, 0, 5'd2, 8'h3C);
    rd1(0, 5'd2, "R4 clock space write/read");
    rd1(1, 5'd2, "R4 RAM untouched by clock write");

    // R3: write-protect bit
    wr1(0, 1, 5'd5, 8'hFF);
    rd1(1, 5'd5, "R3 write blocked when bit 7 is 0");

    // R6: extra byte after single write
    start_tx(1);
    send_byte(mk_cmd(1, 1, 5'd7, 0));
    send_byte(8'h11);
    send_byte(8'h22);
    end_tx();
    exp_ram[7] = 8'h11;
    rd1(1, 5'd7, "R6 single write data");
    rd1(1, 5'd8, "R6 extra byte ignored");

    // R9: partial data byte dropped, R1: fresh command afterwards
    start_tx(1);
    send_byte(mk_cmd(1, 1, 5'd9, 0));
    for (int i = 0; i < 5; i++) bit_cycle(1'b1);
    end_tx();
    rd1(1, 5'd9, "R9 partial byte discarded");
    start_tx(1);
    for (int i = 0; i < 3; i++) bit_cycle(1'b1);
    end_tx();
    wr1(1, 1, 5'd9, 8'h5A);
    rd1(1, 5'd9, "R1 fresh command after aborted one");

    // R7: burst write 32 bytes, 32nd ignored
    start_tx(1);
    send_byte(mk_cmd(1, 1, 5'd31, 0));
    for (int i = 0; i < 32; i++) begin
      send_byte(8'(i * 7 + 3));
      if (i < 31) exp_ram[i] = 8'(i * 7 + 3);
    end
    end_tx();
    begin
      logic [7:0] v;
      start_tx(0);
      send_byte(mk_cmd(1, 1, 5'd31, 1));
      for (int i = 0; i < 31; i++) begin
        recv_byte(v, "R8 burst read drive");
        chk(v == exp_ram[i], "R7 burst read data", v, exp_ram[i]);
      end
      @(negedge clk); sclk = 1'b0;
      repeat (4) @(negedge clk);
      chk(!sdio_oe, "R7 line released after 31 burst bytes", sdio_oe, 0);
      end_tx();
    end
    rd1(1, 5'd0, "R7 no wrap to address 0");

    // R7: short clock-space burst
    start_tx(1);
    send_byte(mk_cmd(1, 0, 5'd31, 0));
    send_byte(8'hC1); send_byte(8'hC2); send_byte(8'hC3);
    end_tx();
    exp_clk[0] = 8'hC1; exp_clk[1] = 8'hC2; exp_clk[2] = 8'hC3;
    rd1(0, 5'd1, "R7 clock burst middle byte");
    rd1(0, 5'd3, "R7 clock burst stopped at ce");

    // R1: ce dropped mid read
    start_tx(0);
    send_byte(mk_cmd(1, 1, 5'd5, 1));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    @(negedge clk); ce = 1'b0;
    repeat (2) @(negedge clk);
    chk(!sdio_oe, "R1 line released after mid-read abort", sdio_oe, 0);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    rd1(1, 5'd5, "R1 read after abort");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule